// File: doc/BRIEF.md
# Programmable-Period Watchdog Timer

This block is a watchdog counter clocked by a slow tick strobe. Each tick advances a prescaler whose length is chosen by a 4-bit period code. An optional postscaler then divides further. When both stages reach their last count, the block emits a one-clock timeout pulse, and counting starts again from zero. Software sees a byte-wide control register that holds the period code and a software run bit. A hard configuration input forces the watchdog to run no matter what that bit holds.

A separate option input decides whether the postscaler belongs to the watchdog and sets its ratio. Several events return both counts to zero:

- a clear command;
- an oscillator-failure event;
- a wake from sleep.

On a wake from sleep, the clock-source class decides when that reset happens. RC, internal and external-clock sources reset the counts at once. A crystal-type source defers the reset until the oscillator start-up timer reports done.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the control register reads 0x08 and the timeout output is 0. The value 0x08 means period code 0100 (bits 4..1) and software run bit 0 (bit 0).
- R2: In the control register, bits 4..1 are the period code and bit 0 is the software run bit. Bits 7..5 always read 0. A written value is visible on the read port in the next cycle.
- R3: Period codes 0 to 11 give a prescaler length of 32 << code ticks.
- R4: Period codes 12 to 15 give the longest prescaler length, 65536 ticks.
- R5: The watchdog runs when the configuration enable is 1 or the software run bit is 1. While it is stopped, both counts stay at zero and no timeout occurs, so a restart begins a full period.
- R6: When the postscaler-assign input is 1, the postscaler ratio is 2^sel, using the 3-bit select input. When the assign input is 0, the ratio is 1. A timeout period is the prescaler length times the postscaler ratio, in ticks.
- R7: The timeout pulse is high for exactly one clock. It appears in the cycle after the tick that completes the period, and the next period starts from zero.
- R8: A clear command returns both counts to zero.
- R9: An oscillator-failure event returns both counts to zero.
- R10: A sleep-exit event with clock class 0 (RC, internal or external clock) returns both counts to zero at once.
- R11: A sleep-exit event with clock class 1 (crystal) leaves the counts running. Both counts return to zero only when the start-up-timer done strobe arrives.
- R12: When a clear of any kind coincides with the completing tick, the clear takes effect and no timeout pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| tickEn | input | 1 | Slow time-base strobe, one clock per tick |
| cfgEnable | input | 1 | Hard enable that software cannot override |
| regWrEn | input | 1 | Write strobe for the control register |
| regWrData | input | 8 | Control register write data |
| regRdData | output | 8 | Control register read data |
| postAssign | input | 1 | 1 = postscaler belongs to the watchdog |
| postSel | input | 3 | Postscaler ratio select (2^sel) |
| clrCmd | input | 1 | Software clear command |
| oscFail | input | 1 | Oscillator-failure event |
| sleepExit | input | 1 | Wake-from-sleep event |
| clkClass | input | 1 | Clock-source class: 0 = RC/internal/external, 1 = crystal |
| ostDone | input | 1 | Oscillator start-up timer done strobe |
| timeoutPulse | output | 1 | One-clock timeout indication |

## Verification
The timeout pulse lags the completing tick by one register stage. Each tick is driven for one cycle and the output is sampled on the following falling edge, so the number of ticks driven when the pulse first shows is the measured period. The read port is combinational from the register, so a write is checked one falling edge after the write cycle. Clear events are applied in a cycle of their own, or together with the completing tick for R12. Each check counts the ticks after the event, so any lag in the clear appears as a wrong period.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CODE_W       = 4;
  localparam int PRE_MIN_LOG2 = 5;
  localparam int PRE_TOP_CODE = 11;
  localparam int PRE_W        = PRE_MIN_LOG2 + PRE_TOP_CODE;
  localparam int SEL_W        = 3;
  localparam int POST_W       = (1 << SEL_W) - 1;

  typedef struct packed {
    logic              run;
    logic              clear;
    logic              tick;
    logic [CODE_W-1:0] preCode;
    logic              postAssign;
    logic [SEL_W-1:0]  postSel;
  } wdogCtl_t;

  function automatic logic [PRE_W-1:0] preLastCount(input logic [CODE_W-1:0] code);
    int sh;
    sh = PRE_MIN_LOG2 + ((int'(code) > PRE_TOP_CODE) ? PRE_TOP_CODE : int'(code));
    return PRE_W'((33'd1 << sh) - 33'd1);
  endfunction

  function automatic logic [POST_W-1:0] postLastCount(input logic asg,
                                                      input logic [SEL_W-1:0] sel);
    return asg ? POST_W'((32'd1 << sel) - 32'd1) : '0;
  endfunction
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tickEn,
  input  logic       cfgEnable,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       postAssign,
  input  logic [SEL_W-1:0] postSel,
  input  logic       clrCmd,
  input  logic       oscFail,
  input  logic       sleepExit,
  input  logic       clkClass,
  input  logic       ostDone,
  output wdogCtl_t   ctl
);
  localparam logic [CODE_W-1:0] CODE_RESET = 4'b0100;

  logic [CODE_W-1:0] periodCode;
  logic              swRun;
  logic              xtalWait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      periodCode <= CODE_RESET;
      swRun      <= 1'b0;
      xtalWait   <= 1'b0;
    end else begin
      if (regWrEn) begin
        periodCode <= regWrData[CODE_W:1];
        swRun      <= regWrData[0];
      end
      xtalWait <= (xtalWait & ~ostDone) | (sleepExit & clkClass);
    end
  end

  assign regRdData = {{(8-CODE_W-1){1'b0}}, periodCode, swRun};

  always_comb begin
    ctl.run        = cfgEnable | swRun;
    ctl.clear      = clrCmd | oscFail | (sleepExit & ~clkClass) | (ostDone & xtalWait);
    ctl.tick       = tickEn;
    ctl.preCode    = periodCode;
    ctl.postAssign = postAssign;
    ctl.postSel    = postSel;
  end

  p_wr_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    regWrEn |=> (regRdData[4:0] == $past(regWrData[4:0])));
  p_rd_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
    regWrEn |=> (regRdData[7:5] == 3'b000) || ($past(regWrData[7:5]) != 3'b000) || 1'b1 == (regRdData[7:5] == 3'b000));
endmodule

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  wdogCtl_t ctl,
  output logic     timeoutPulse
);
  logic [PRE_W-1:0]  preCnt;
  logic [POST_W-1:0] postCnt;
  logic [PRE_W-1:0]  preLast;
  logic [POST_W-1:0] postLast;
  logic              preEnd;
  logic              postEnd;

  assign preLast  = preLastCount(ctl.preCode);
  assign postLast = postLastCount(ctl.postAssign, ctl.postSel);
  assign preEnd   = (preCnt >= preLast);
  assign postEnd  = (postCnt >= postLast);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preCnt       <= '0;
      postCnt      <= '0;
      timeoutPulse <= 1'b0;
    end else if (!ctl.run || ctl.clear) begin
      preCnt       <= '0;
      postCnt      <= '0;
      timeoutPulse <= 1'b0;
    end else if (ctl.tick) begin
      if (preEnd) begin
        preCnt <= '0;
        if (postEnd) begin
          postCnt      <= '0;
          timeoutPulse <= 1'b1;
        end else begin
          postCnt      <= postCnt + 1'b1;
          timeoutPulse <= 1'b0;
        end
      end else begin
        preCnt       <= preCnt + 1'b1;
        timeoutPulse <= 1'b0;
      end
    end else begin
      timeoutPulse <= 1'b0;
    end
  end

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    timeoutPulse |=> !timeoutPulse);
  p_pulse_from_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    timeoutPulse |-> ($past(ctl.tick) && $past(ctl.run) && preCnt == '0 && postCnt == '0));
  p_stopped_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.run |=> (!timeoutPulse && preCnt == '0 && postCnt == '0));
  p_clear_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.clear |=> (!timeoutPulse && preCnt == '0 && postCnt == '0));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tickEn,
  input  logic       cfgEnable,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       postAssign,
  input  logic [2:0] postSel,
  input  logic       clrCmd,
  input  logic       oscFail,
  input  logic       sleepExit,
  input  logic       clkClass,
  input  logic       ostDone,
  output logic       timeoutPulse
);
  wdogCtl_t ctl;

  wdog_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .cfgEnable(cfgEnable),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .postAssign(postAssign), .postSel(postSel), .clrCmd(clrCmd),
    .oscFail(oscFail), .sleepExit(sleepExit), .clkClass(clkClass),
    .ostDone(ostDone), .ctl(ctl)
  );

  wdog_dp dp_i (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .timeoutPulse(timeoutPulse)
  );
endmodule

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tickEn = 1'b0, cfgEnable = 1'b0, regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic postAssign = 1'b0;
  logic [2:0] postSel = '0;
  logic clrCmd = 1'b0, oscFail = 1'b0, sleepExit = 1'b0, clkClass = 1'b0, ostDone = 1'b0;
  logic timeoutPulse;

  int checks = 0;
  int errors = 0;
  int cycleCnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdog_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .cfgEnable(cfgEnable),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .postAssign(postAssign), .postSel(postSel), .clrCmd(clrCmd),
    .oscFail(oscFail), .sleepExit(sleepExit), .clkClass(clkClass),
    .ostDone(ostDone), .timeoutPulse(timeoutPulse)
  );

  always @(posedge clk) begin
    cycleCnt <= cycleCnt + 1;
    if (cycleCnt > 190000 && !done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired: actual %0d cycles expected < 190000", cycleCnt);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int expPeriod(input int code, input bit asg, input int sel);
    int c;
    c = (code > 11) ? 11 : code;
    return (32 << c) * (asg ? (1 << sel) : 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic t);
    tickEn = t;
    @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    regWrEn = 1'b1;
    regWrData = d;
    cyc(1'b0);
    regWrEn = 1'b0;
  endtask

  task automatic ticks(input int n, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      cyc(1'b1);
      if (timeoutPulse) seen = 1'b1;
    end
  endtask

  task automatic measure(input int pct, input int limit, output int n);
    bit hit;
    n = 0;
    hit = 1'b0;
    for (int i = 0; i < limit * 4 + 200 && !hit; i++) begin
      bit t;
      t = (($urandom % 100) < pct);
      cyc(t);
      if (t) n++;
      if (timeoutPulse) hit = 1'b1;
    end
    if (!hit) n = -1;
  endtask

  initial begin
    int n;
    bit seen;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(regRdData == 8'h08, "R1 reset register", regRdData, 8'h08);
    check(timeoutPulse == 1'b0, "R1 reset timeout", timeoutPulse, 0);

    // R2 register layout and readback
    wr(8'hFF);
    check(regRdData == 8'h1F, "R2 readback with padding", regRdData, 8'h1F);
    wr(8'h0A);
    check(regRdData == 8'h0A, "R2 readback", regRdData, 8'h0A);

    // R5 stopped: no timeout while both enables are 0
    wr(8'h00);
    ticks(200, seen);
    check(!seen, "R5 stopped no timeout", seen, 0);

    // R5 configuration enable overrides software bit 0
    cfgEnable = 1'b1;
    measure(100, 32, n);
    check(n == 32, "R5 cfg enable runs", n, 32);
    cfgEnable = 1'b0;

    // R7 one-clock pulse and restart from zero
    wr(8'h01);
    measure(100, 32, n);
    check(n == 32, "R3 code 0 period", n, 32);
    cyc(1'b0);
    check(timeoutPulse == 1'b0, "R7 pulse one clock", timeoutPulse, 0);
    measure(60, 32, n);
    check(n == 32, "R7 restart from zero", n, 32);

    // R5 restart after stop begins a full period
    ticks(10, seen);
    wr(8'h00);
    repeat (3) cyc(1'b1);
    wr(8'h01);
    measure(100, 32, n);
    check(n == 32, "R5 stop clears counts", n, 32);

    // R8 clear command
    ticks(20, seen);
    clrCmd = 1'b1; cyc(1'b0); clrCmd = 1'b0;
    measure(100, 32, n);
    check(n == 32, "R8 clear command", n, 32);

    // R9 oscillator failure
    ticks(20, seen);
    oscFail = 1'b1; cyc(1'b0); oscFail = 1'b0;
    measure(100, 32, n);
    check(n == 32, "R9 osc fail clear", n, 32);

    // R10 sleep exit, class 0
    ticks(20, seen);
    sleepExit = 1'b1; clkClass = 1'b0; cyc(1'b0); sleepExit = 1'b0;
    measure(100, 32, n);
    check(n == 32, "R10 sleep exit immediate", n, 32);

    // R11 sleep exit, class 1: clear only at start-up done
    ticks(10, seen);
    sleepExit = 1'b1; clkClass = 1'b1; cyc(1'b0); sleepExit = 1'b0; clkClass = 1'b0;
    ticks(5, seen);
    check(!seen, "R11 no early timeout", seen, 0);
    ostDone = 1'b1; cyc(1'b0); ostDone = 1'b0;
    measure(100, 32, n);
    check(n == 32, "R11 clear at start-up done", n, 32);

    // R12 clear on the completing tick
    ticks(31, seen);
    check(!seen, "R12 before terminal", seen, 0);
    clrCmd = 1'b1; cyc(1'b1); clrCmd = 1'b0;
    check(timeoutPulse == 1'b0, "R12 clear wins", timeoutPulse, 0);
    measure(100, 32, n);
    check(n == 32, "R12 period after clear", n, 32);

    // R6 largest postscaler with the shortest prescaler
    wr(8'h00);
    postAssign = 1'b1; postSel = 3'd7;
    wr(8'h01);
    measure(100, 4096, n);
    check(n == 4096, "R6 postscaler 1:128", n, 4096);

    // R3/R6 random trials
    for (int k = 0; k < 8; k++) begin
      int code, sel, pct, e;
      bit asg;
      code = $urandom % 4;
      asg = $urandom % 2;
      sel = $urandom % 4;
      pct = 30 + ($urandom % 70);
      wr(8'h00);
      postAssign = asg; postSel = 3'(sel);
      wr(8'((code << 1) | 1));
      e = expPeriod(code, asg, sel);
      measure(pct, e, n);
      check(n == e, "R3 R6 random period", n, e);
    end

    // R4 saturated code
    wr(8'h00);
    postAssign = 1'b0; postSel = 3'd0;
    wr(8'h1F);
    measure(100, 65536, n);
    check(n == 65536, "R4 code 15 period", n, 65536);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule